// File: doc/BRIEF.md
# Irregular-Sequence Synchronous Counter

This block is a 4-bit synchronous counter. Its state sits in D-type registers and is updated on the rising clock edge. While counting is enabled, the state walks a fixed cycle of seven non-binary values: 2, 3, 5, 7, 10, 12, 14. After 14 it returns to 2.

The other nine codes are treated as off-sequence. On the next enabled edge, any of them goes to the recovery code 6. Code 6 is itself off-sequence, so it maps to itself. The synchronous reset is therefore the only way back into the cycle. A combinational flag reports whenever the current state is off-sequence.

The reset value is a parameter and defaults to 2. Overriding it lets a verification environment start an instance in any of the 16 codes without adding a load port.

Top module: `irr_seq_counter`

## Requirements
- R1: When `rst_i` is high at a rising edge, the state becomes `RST_CODE` (default 2) after that edge.
- R2: When enabled and out of reset, each listed value steps to the next entry of the cycle on each edge: 2→3, 3→5, 5→7, 7→10, 10→12, 12→14.
- R3: When enabled, state 14 steps to 2, so the seven values repeat without end.
- R4: When enabled, every code outside the cycle (0, 1, 4, 6, 8, 9, 11, 13, 15) steps to 6 on the next edge. Code 6 therefore stays at 6.
- R5: When `en_i` is low and reset is low, the state holds its value. This includes off-sequence codes.
- R6: `off_seq_o` is 1 exactly when the current state is not one of the seven cycle values. It follows the state with no added delay.
- R7: Reset takes priority over enable. Reset with enable high still loads `RST_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; when low, the state holds |
| state_o | output | 4 | Current counter value |
| off_seq_o | output | 1 | High when the state is outside the seven-value cycle |

## Verification
On every clock, the assertions check four things:
- a reset edge lands on the reset code;
- a disabled edge leaves the state unchanged;
- an enabled off-sequence state lands on 6, and the last cycle value wraps to the first;
- a legal state never steps out of the cycle.

Inside the decoder, a further check confirms that at most one cycle entry matches the current state.

Only the bench scenarios can show that the successor is exactly right for each of the 16 codes, including the 6→6 lock. To do this, the bench uses sixteen instances whose reset codes are overridden. It also runs two full passes of the cycle and a long random mix of reset and enable.

// File: rtl/irr_seq_pkg.sv
`timescale 1ns/1ps
package irr_seq_pkg;
  localparam int CODE_W = 4;
  localparam int SEQ_LEN = 7;
  typedef logic [CODE_W-1:0] code_t;

  // Cycle order matters: entry i steps to entry (i+1) mod SEQ_LEN.
  localparam code_t SEQ_LIST [SEQ_LEN] = '{4'd2, 4'd3, 4'd5, 4'd7, 4'd10, 4'd12, 4'd14};
  localparam code_t RECOVER_CODE = 4'd6;

  // Position of a code in the cycle, or -1 when it is off-sequence.
  function automatic int seq_index(code_t c);
    int idx;
    idx = -1;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (c == SEQ_LIST[i]) idx = i;
    end
    return idx;
  endfunction

  // Successor of a code under the cycle and recovery rules.
  function automatic code_t seq_follow(code_t c);
    int idx;
    idx = seq_index(c);
    if (idx < 0) return RECOVER_CODE;
    return SEQ_LIST[(idx + 1) % SEQ_LEN];
  endfunction
endpackage

// File: rtl/irr_seq_decode.sv
`timescale 1ns/1ps
module irr_seq_decode
  import irr_seq_pkg::*;
(
  input  code_t cur_i,
  output logic  member_o,
  output code_t next_o
);
  logic [SEQ_LEN-1:0] hit;

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_hit
    assign hit[g] = (cur_i == SEQ_LIST[g]);
  end

  always_comb begin
    next_o = RECOVER_CODE;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (hit[i]) next_o = SEQ_LIST[(i + 1) % SEQ_LEN];
    end
  end

  assign member_o = |hit;

  // R6
  always_comb begin
    single_hit_chk: assert ($onehot0(hit));
  end

  // R2
  always_comb begin
    follow_agree_chk: assert (next_o == seq_follow(cur_i));
  end
endmodule

// File: rtl/irr_seq_state.sv
`timescale 1ns/1ps
module irr_seq_state
  import irr_seq_pkg::*;
#(
  parameter code_t RST_V = 4'd2
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  en_i,
  input  code_t d_i,
  output code_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= RST_V;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/irr_seq_counter.sv
`timescale 1ns/1ps
module irr_seq_counter
  import irr_seq_pkg::*;
#(
  parameter int unsigned RST_CODE = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  output logic [CODE_W-1:0] state_o,
  output logic              off_seq_o
);
  localparam code_t RST_V = code_t'(RST_CODE);

  code_t cur_w;
  code_t next_w;
  logic  member_w;
  logic  step_w;
  logic  recover_w;

  irr_seq_decode u_dec (
    .cur_i   (cur_w),
    .member_o(member_w),
    .next_o  (next_w)
  );

  irr_seq_state #(.RST_V(RST_V)) u_reg (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .en_i (en_i),
    .d_i  (next_w),
    .q_o  (cur_w)
  );

  assign step_w    = en_i & ~rst_i;
  assign recover_w = step_w & ~member_w;
  assign state_o   = cur_w;
  assign off_seq_o = ~member_w;

  // R1
  reset_load_chk: assert property (@(posedge clk_i)
    rst_i |=> state_o == RST_V);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(state_o));

  // R4
  recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    recover_w |=> state_o == RECOVER_CODE);

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_w && state_o == SEQ_LIST[SEQ_LEN-1]) |=> state_o == SEQ_LIST[0]);

  // R2
  closed_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_w && !off_seq_o) |=> !off_seq_o);
endmodule

// File: tb/sim_irr_seq_counter.sv
`timescale 1ns/1ps
module sim_irr_seq_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic en = 1'b0;
  logic [3:0] state;
  logic off_seq;
  int tests = 0;
  int fails = 0;

  irr_seq_counter u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .state_o(state), .off_seq_o(off_seq)
  );

  // Sixteen instances, each resetting into a different code.
  logic arr_rst = 1'b1;
  logic arr_en = 1'b0;
  logic [3:0] code_state [16];
  logic [15:0] code_flag;
  for (genvar k = 0; k < 16; k++) begin : g_code
    irr_seq_counter #(.RST_CODE(k)) u_k (
      .clk_i(clk), .rst_i(arr_rst), .en_i(arr_en),
      .state_o(code_state[k]), .off_seq_o(code_flag[k])
    );
  end

  function automatic bit is_main(int v);
    case (v)
      2, 3, 5, 7, 10, 12, 14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int succ(int v);
    case (v)
      2: return 3;   3: return 5;   5: return 7;   7: return 10;
      10: return 12; 12: return 14; 14: return 2;
      default: return 6;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  int model = 0;

  task automatic step(bit r, bit e, string req);
    rst = r;
    en = e;
    @(negedge clk);
    if (r) model = 2;
    else if (e) model = succ(model);
    check(req, state, model);
    check("R6", off_seq, is_main(model) ? 0 : 1);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    @(negedge clk);
    step(1, 0, "R1");
    step(1, 1, "R7");
    // two full passes of the cycle, including the 14 -> 2 wrap
    for (int i = 0; i < 14; i++) step(0, 1, (model == 14) ? "R3" : "R2");
    for (int i = 0; i < 3; i++) step(0, 0, "R5");
    for (int i = 0; i < 400; i++) begin
      bit r;
      bit e;
      r = ($urandom % 16) == 0;
      e = $urandom % 2;
      step(r, e, r ? "R1" : (e ? "R2" : "R5"));
    end

    // every code: reset value, hold, then two successors
    arr_rst = 1'b1; arr_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      check("R1", code_state[k], k);
      check("R6", code_flag[k], is_main(k) ? 0 : 1);
    end
    arr_rst = 1'b0; arr_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 16; k++) check("R5", code_state[k], k);
    arr_en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++)
      check(is_main(k) ? "R2" : "R4", code_state[k], succ(k));
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      check("R4", code_state[k], succ(succ(k)));
      check("R6", code_flag[k], is_main(succ(succ(k))) ? 0 : 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule